// File: doc/BRIEF.md
# Status-Bit Polling Completion Controller

This controller sits on the host side of a NOR-style flash device. After the host has fully written a program or erase command sequence to the device, it starts the controller. The controller then reads the device repeatedly through a simple synchronous read port and decides when the embedded operation has finished by watching one status bit, bit 7. Bits 6..0 may still be settling on the read where bit 7 flips, so the controller always issues one confirming read before it reports completion. It returns the word from that confirming read.

A start request carries the operation kind, a base address, an offset for buffered programs, the expected data word and a limit on the number of poll reads. The controller picks the address to poll. It compares bit 7 of each returned word against a target that depends on the operation. It flags a verify error when a program's confirmed word is not the expected word, and it flags a timeout when the poll budget runs out. All results are registered and stay valid until the next start.

Top module: `dq7_poll_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `busy`, `done`, `mem_rd_en`, `timeout` and `verify_err` are 0 and `result_data` is 0.
- R2: A start request is accepted only when the controller is idle (`busy` low). A `start_valid` pulse seen while busy has no effect on the reads issued or on the results. No read is issued while idle.
- R3: The operation code `start_op` selects the poll address. Code 0 (program) uses `start_addr`, and so do code 1 (erase) and code 3 (treated as program). Code 2 (buffered program) uses `start_addr + start_last_ofs`. Every read of an operation uses that one address.
- R4: Each read is a one-cycle `mem_rd_en` pulse. The next read is not requested until `mem_rd_valid` has returned the previous word. The first request is driven in the cycle after the start is accepted.
- R5: For program codes (0, 2, 3), a poll read completes polling when its bit 7 equals bit 7 of `start_data`.
- R6: For erase (code 1), a poll read completes polling when its bit 7 is 1, whatever `start_data` holds.
- R7: After the first completing poll read, exactly one more read is issued to the same address. `result_data` is the full word returned by that confirming read.
- R8: For program codes, `verify_err` is set when the confirming word differs in any bit from `start_data`. For erase, `verify_err` is never set.
- R9: At most max(`poll_limit`,1) poll reads are issued. If none of them completes, the operation ends with `timeout` set and `result_data` equal to the last poll word. The confirming read does not count toward the limit.
- R10: `done` is a single-cycle pulse. `timeout`, `verify_err` and `result_data` hold their values after `done` until the next accepted start.
- R11: With a memory that returns data one cycle after each request, an operation that issues n reads raises `done` 2n cycles after the clock edge that accepts the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start request, sampled when idle |
| start_op | input | 2 | Operation code: 0 program, 1 erase, 2 buffered program, 3 program |
| start_addr | input | AW | Program address, sector address, or buffer base |
| start_last_ofs | input | OW | Offset of the last buffered word (code 2 only) |
| start_data | input | DW | Expected data word (last word for code 2) |
| poll_limit | input | CW | Maximum poll reads; 0 acts as 1 |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | DW | Returned read word |
| mem_rd_valid | input | 1 | Returned word is valid this cycle |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Poll budget exhausted |
| verify_err | output | 1 | Confirmed word differs from expected (program) |
| result_data | output | DW | Confirmed word, or last poll word on timeout |

## Verification
The bench memory answers each request one cycle later, so every read costs exactly two cycles: the request cycle plus the wait cycle in which the returned word is sampled. The run for each vector counts clock edges from the one that accepts the start up to the negative edge where `done` is first seen, and compares that count with twice the expected number of reads. The flags and `result_data` are sampled in that same half-cycle. The bench samples once more a cycle later to confirm that `done` has dropped while the results hold. Requests, addresses and read counts are captured by the memory model at each rising edge, so nothing depends on the order of processes at the edge.

// File: rtl/dq7_poll_pkg.sv
package dq7_poll_pkg;
  typedef enum logic [1:0] {
    OP_PROG    = 2'd0,
    OP_ERASE   = 2'd1,
    OP_BUFPROG = 2'd2,
    OP_ALTPROG = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_POLL_REQ  = 3'd1,
    ST_POLL_WAIT = 3'd2,
    ST_CONF_REQ  = 3'd3,
    ST_CONF_WAIT = 3'd4,
    ST_DONE      = 3'd5
  } state_e;
endpackage

// File: rtl/poll_addr_sel.sv
module poll_addr_sel
  import dq7_poll_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 4
) (
  input  op_e           op,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] last_ofs,
  output logic [AW-1:0] addr
);
  localparam int PADW = AW - OW;

  always_comb begin
    if (op == OP_BUFPROG) addr = base + {{PADW{1'b0}}, last_ofs};
    else                  addr = base;
  end
endmodule

// File: rtl/status_cmp.sv
module status_cmp
  import dq7_poll_pkg::*;
#(
  parameter int DW = 16,
  parameter int SB = 7
) (
  input  op_e           op,
  input  logic [DW-1:0] expect_word,
  input  logic [DW-1:0] rd_word,
  output logic          bit_hit,
  output logic          word_miss
);
  logic target;

  always_comb begin
    target    = (op == OP_ERASE) ? 1'b1 : expect_word[SB];
    bit_hit   = (rd_word[SB] == target);
    word_miss = (op != OP_ERASE) && (rd_word != expect_word);
  end
endmodule

// File: rtl/poll_budget_ctr.sv
module poll_budget_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] limit,
  input  logic          step,
  output logic          last
);
  logic [CW-1:0] lim_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= (limit == '0) ? CW'(1) : limit;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    last = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, lim_q};
  end

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (rst)
    (lim_q != '0) |-> (cnt_q < lim_q)); // R9
  AST_STEP_IN_BUDGET: assert property (@(posedge clk) disable iff (rst)
    step |-> !last); // R9
endmodule

// File: rtl/dq7_poll_ctrl.sv
module dq7_poll_ctrl
  import dq7_poll_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OW = 4,
  parameter int CW = 8,
  parameter int SB = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [OW-1:0] start_last_ofs,
  input  logic [DW-1:0] start_data,
  input  logic [CW-1:0] poll_limit,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          mem_rd_valid,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          verify_err,
  output logic [DW-1:0] result_data
);
  state_e        state_q, state_d;
  op_e           op_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] sel_addr;
  logic          rd_en_q, busy_q, done_q, timeout_q, verr_q;
  logic [DW-1:0] result_q;
  logic          accept, bit_hit, word_miss, last_poll, step;

  poll_addr_sel #(.AW(AW), .OW(OW)) u_addr (
    .op       (op_e'(start_op)),
    .base     (start_addr),
    .last_ofs (start_last_ofs),
    .addr     (sel_addr)
  );

  status_cmp #(.DW(DW), .SB(SB)) u_cmp (
    .op          (op_q),
    .expect_word (exp_q),
    .rd_word     (mem_rd_data),
    .bit_hit     (bit_hit),
    .word_miss   (word_miss)
  );

  poll_budget_ctr #(.CW(CW)) u_budget (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .limit (poll_limit),
    .step  (step),
    .last  (last_poll)
  );

  always_comb begin
    accept  = (state_q == ST_IDLE) && start_valid;
    step    = (state_q == ST_POLL_WAIT) && mem_rd_valid && !bit_hit && !last_poll;
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start_valid) state_d = ST_POLL_REQ;
      ST_POLL_REQ:  state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (mem_rd_valid) begin
          if (bit_hit)        state_d = ST_CONF_REQ;
          else if (last_poll) state_d = ST_DONE;
          else                state_d = ST_POLL_REQ;
        end
      end
      ST_CONF_REQ:  state_d = ST_CONF_WAIT;
      ST_CONF_WAIT: if (mem_rd_valid) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PROG;
      exp_q     <= '0;
      addr_q    <= '0;
      rd_en_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      verr_q    <= 1'b0;
      result_q  <= '0;
    end else begin
      state_q <= state_d;
      rd_en_q <= (state_d == ST_POLL_REQ) || (state_d == ST_CONF_REQ);
      busy_q  <= (state_d != ST_IDLE);
      done_q  <= (state_d == ST_DONE);
      if (accept) begin
        op_q      <= op_e'(start_op);
        exp_q     <= start_data;
        addr_q    <= sel_addr;
        timeout_q <= 1'b0;
        verr_q    <= 1'b0;
        result_q  <= '0;
      end
      if ((state_q == ST_POLL_WAIT) && mem_rd_valid && !bit_hit && last_poll) begin
        timeout_q <= 1'b1;
        result_q  <= mem_rd_data;
      end
      if ((state_q == ST_CONF_WAIT) && mem_rd_valid) begin
        result_q <= mem_rd_data;
        verr_q   <= word_miss;
      end
    end
  end

  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = addr_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign timeout     = timeout_q;
  assign verify_err  = verr_q;
  assign result_data = result_q;

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R4
  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_rd_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    done |-> !(timeout && verify_err)); // R8
  AST_ERASE_NO_VERR: assert property (@(posedge clk) disable iff (rst)
    (done && (op_q == OP_ERASE)) |-> !verify_err); // R8
endmodule

// File: tb/tb_dq7_poll_ctrl.sv
module tb_dq7_poll_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int CW = 8;
  localparam int VW = 80;
  localparam int NV = 10;

  // mode, addr, ofs, data, busy_reads, limit, final, exp_reads, exp_to, exp_verr
  localparam logic [VW-1:0] VECS [NV] = '{
    {2'd0, 16'h1234, 4'h0, 16'hA5C3, 8'd3,  8'd10, 16'hA5C3, 8'd5, 1'b0, 1'b0},
    {2'd0, 16'h0042, 4'h0, 16'h1234, 8'd0,  8'd10, 16'h1234, 8'd2, 1'b0, 1'b0},
    {2'd1, 16'h0400, 4'h0, 16'h0000, 8'd5,  8'd10, 16'hFFFF, 8'd7, 1'b0, 1'b0},
    {2'd2, 16'h2000, 4'hF, 16'hBEEF, 8'd2,  8'd10, 16'hBEEF, 8'd4, 1'b0, 1'b0},
    {2'd0, 16'h0077, 4'h0, 16'h00FF, 8'd1,  8'd10, 16'h01FF, 8'd3, 1'b0, 1'b1},
    {2'd0, 16'h0088, 4'h0, 16'h4411, 8'd20, 8'd4,  16'h4411, 8'd4, 1'b1, 1'b0},
    {2'd1, 16'h0500, 4'h0, 16'h0000, 8'd9,  8'd0,  16'hFFFF, 8'd1, 1'b1, 1'b0},
    {2'd0, 16'h0099, 4'h0, 16'h0101, 8'd3,  8'd4,  16'h0101, 8'd5, 1'b0, 1'b0},
    {2'd3, 16'h0030, 4'h5, 16'h0080, 8'd1,  8'd10, 16'h0080, 8'd3, 1'b0, 1'b0},
    {2'd1, 16'h0600, 4'h3, 16'h1234, 8'd0,  8'd10, 16'h00F0, 8'd2, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic [1:0]    start_op = '0;
  logic [AW-1:0] start_addr = '0;
  logic [OW-1:0] start_last_ofs = '0;
  logic [DW-1:0] start_data = '0;
  logic [CW-1:0] poll_limit = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          mem_rd_valid;
  logic          busy, done, timeout, verify_err;
  logic [DW-1:0] result_data;

  int checks = 0;
  int errors = 0;
  int wd_cycles = 0;

  logic          m_clr = 1'b0;
  int            m_b = 0;
  logic [DW-1:0] m_busy = '0;
  logic [DW-1:0] m_final = '0;
  logic [AW-1:0] m_exp_addr = '0;
  int            rd_cnt;
  logic          addr_bad;

  always #5 clk = ~clk;

  dq7_poll_ctrl #(.AW(AW), .DW(DW), .OW(OW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_op(start_op),
    .start_addr(start_addr), .start_last_ofs(start_last_ofs), .start_data(start_data),
    .poll_limit(poll_limit), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid), .busy(busy), .done(done),
    .timeout(timeout), .verify_err(verify_err), .result_data(result_data)
  );

  // memory model: one-cycle latency; word on the flipping read has lagging low bits
  always @(posedge clk) begin
    if (m_clr) begin
      rd_cnt       <= 0;
      addr_bad     <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else if (mem_rd_en) begin
      mem_rd_valid <= 1'b1;
      if (rd_cnt < m_b)       mem_rd_data <= m_busy;
      else if (rd_cnt == m_b) mem_rd_data <= m_final ^ 16'h007F;
      else                    mem_rd_data <= m_final;
      rd_cnt <= rd_cnt + 1;
      if (mem_rd_addr != m_exp_addr) addr_bad <= 1'b1;
    end else begin
      mem_rd_valid <= 1'b0;
    end
  end

  always @(posedge clk) begin
    wd_cycles <= wd_cycles + 1;
    if (wd_cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", wd_cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one operation; a second start is injected at cycle inj (if >= 0).
  task automatic run_op(input logic [1:0] mode, input logic [15:0] addr,
                        input logic [3:0] ofs, input logic [15:0] data, input int b,
                        input logic [7:0] lim, input logic [15:0] fin, input int erd,
                        input bit eto, input bit eve, input int inj);
    logic tgt;
    logic [15:0] exp_res;
    int cyc;
    tgt        = (mode == 2'd1) ? 1'b1 : data[7];
    m_busy     = {8'h3C, ~tgt, 7'h5A};
    m_final    = fin;
    m_b        = b;
    m_exp_addr = (mode == 2'd2) ? addr + {12'h000, ofs} : addr;
    exp_res    = eto ? m_busy : fin;
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
    start_valid = 1'b1; start_op = mode; start_addr = addr; start_last_ofs = ofs;
    start_data = data; poll_limit = lim;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (cyc == inj) begin
        start_valid = 1'b1; start_op = 2'd1; start_addr = 16'h7777; start_data = 16'h0000;
        poll_limit = 8'd1;
      end else begin
        start_valid = 1'b0;
      end
      @(posedge clk);
      cyc = cyc + 1;
      @(negedge clk);
    end
    start_valid = 1'b0;
    check(cyc == 2 * erd, "R11 done latency", cyc, 2 * erd);
    check(rd_cnt == erd, "R5/R6/R7/R9 read count", rd_cnt, erd);
    check(!addr_bad, "R3 poll address", addr_bad, 0);
    check(timeout == eto, "R9 timeout flag", timeout, eto);
    check(verify_err == eve, "R8 verify flag", verify_err, eve);
    check(result_data == exp_res, "R7 result word", result_data, exp_res);
    @(negedge clk);
    check(!done, "R10 done single pulse", done, 0);
    check(result_data == exp_res && timeout == eto && verify_err == eve,
          "R10 results held", result_data, exp_res);
    check(!busy, "R2 idle after op", busy, 0);
  endtask

  initial begin
    m_clr = 1'b1;
    rst   = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !mem_rd_en && !timeout && !verify_err && result_data == '0,
          "R1 outputs in reset", {busy, done, mem_rd_en, timeout, verify_err}, 0);
    rst = 1'b0;
    m_clr = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_rd_en && result_data == '0,
          "R1 outputs after reset", {busy, done, mem_rd_en}, 0);

    // R2: no reads while idle without a start
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!mem_rd_en && !busy, "R2 idle no read", mem_rd_en, 0);
    end

    // table of vectors: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v][79:78], VECS[v][77:62], VECS[v][61:58], VECS[v][57:42],
             int'(VECS[v][41:34]), VECS[v][33:26], VECS[v][25:10], int'(VECS[v][9:2]),
             VECS[v][1], VECS[v][0], -1);
    end

    // R2: start presented while busy is ignored
    run_op(2'd0, 16'h0100, 4'h0, 16'h5555, 4, 8'd10, 16'h5555, 6, 1'b0, 1'b0, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busy && !mem_rd_en, "R2 ignored start not replayed", busy, 0);
    end

    // R4: first request in the cycle after the accepting edge
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
    m_b = 50; m_exp_addr = 16'h0A00; m_busy = 16'h3C5A; m_final = 16'hFFFF;
    start_valid = 1'b1; start_op = 2'd1; start_addr = 16'h0A00; poll_limit = 8'd50;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    check(mem_rd_en && busy, "R4 request after accept", mem_rd_en, 1);
    @(negedge clk);
    check(!mem_rd_en, "R4 request is one cycle", mem_rd_en, 0);

    // R1: reset in mid-operation returns to idle
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !mem_rd_en && !done && !timeout, "R1 mid-op reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_rd_en, "R1 idle after mid-op reset", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule